// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block is the digital control for a successive-approximation converter. A write to the channel register starts a conversion on the selected input. The block then counts converter clock ticks through a fixed setup phase and one or more sample phases. At the end of each sample phase it takes a raw code from the `rawSample` port and adds it to an accumulator. After the last sample it scales the sum, masks it to the chosen resolution and stores it as the result. It then sets a completion flag, which raises the interrupt when that is enabled.

The converter clock is a tick enable made from the bus clock by a power-of-two divider. Conversions run once per channel write, or back to back in continuous mode. When a new result arrives before the old one has been read, an overwrite policy decides which one is kept.

Registers are word indices on `regAddr`:

| Index | Register |
|---|---|
| 0 | channel control |
| 1 | configuration |
| 2 | general control |
| 3 | status |
| 4 | result |

Writes take effect at the clock edge. `rdData` is combinational from `regAddr`.

Top module: `adc_conv_seq`

## Requirements
- R1: A write to index 0 with bits [4:0] not equal to 0x1F aborts any running conversion and starts a new one. After that edge `convBusy` is 1, `chanSel` shows bits [4:0] and bit 7 is stored as the interrupt enable. Reading index 0 returns the channel in [4:0] and the enable in bit 7.
- R2: A write to index 0 with bits [4:0] = 0x1F stops the sequencer. `convBusy` drops after that edge and no completion follows.
- R3: One conversion lasts 6 + N×(25+L) converter ticks. The completion flag (index 3, bit 0) first reads 1 right after the edge of the last tick.
- R4: The long-sample adder L comes from configuration bit 4 (long) and bits [9:8] (field f). With long = 0, L = 3+2f. With long = 1, L = 13+4f for f = 0 to 2, and L = 25 for f = 3.
- R5: Averaging is on when general-control bit 5 is set. Configuration bits [15:14] = 0..3 then give N = 4, 8, 16 or 32; with averaging off, N = 1. The raw code is taken at the tick that ends each sample phase and summed in 17 bits. The result is the sum shifted right by log2(N).
- R6: Configuration bits [3:2] = 0, 1, 2 select 8, 10 or 12 bits. The result (index 4, bits [11:0]) is masked to 0xFF, 0x3FF or 0xFFF.
- R7: The converter tick period is 2^d bus cycles, where d is configuration bits [6:5]. When bits [1:0] = 1 and d = 3, the period is 16 instead.
- R8: A read of index 4 (`regRe` = 1) clears the completion flag. `irq` equals the flag AND the stored interrupt enable.
- R9: With general-control bit 6 set, a new conversion starts on the tick that completes the previous one. Once bit 6 is cleared, the sequencer goes idle after the conversion in progress completes.
- R10: Configuration bit 16 is the overwrite enable. With it set, a completion replaces the stored result. With it clear, a completion that arrives while the flag is set is dropped and the old result stays.
- R11: After reset the sequencer is idle. The flag, `irq` and the result are 0, and the channel reads 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears the flag on result reads) |
| regAddr | input | 3 | Register word index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` |
| rawSample | input | 12 | Raw code from the analog converter |
| chanSel | output | 5 | Selected channel |
| convBusy | output | 1 | Conversion in progress |
| cvClkEn | output | 1 | Converter clock tick enable |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is the overwrite decision. It needs a second completion to land while the first result is still unread, and that happens only in continuous mode with a deliberately unread flag. The bench drives the raw input as a ramp that follows the cycle count. Each completion therefore captures a distinct code, and the result register shows which completion survived. The bench lets two completions pass with overwrite off, turns overwrite on for the third, and then clears continuous mode before the fourth. Timing is checked against an exact edge: the flag must be 0 one edge before the computed deadline and 1 at it. This is done for every divider, adder and averaging setting in the table.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CFG_W = 17;

  localparam int A_CHAN = 0;
  localparam int A_CFG  = 1;
  localparam int A_GEN  = 2;
  localparam int A_STAT = 3;
  localparam int A_RES  = 4;

  typedef struct packed {
    logic start;
    logic sampleEn;
    logic finish;
  } seqStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SAMPLE} seqState_t;

  // Long-sample adder in converter ticks (R4)
  function automatic logic [4:0] lsAdder(input logic lng, input logic [1:0] f);
    if (!lng)          return 5'd3 + {2'b0, f, 1'b0};
    else if (f == 2'd3) return 5'd25;
    else               return 5'd13 + {1'b0, f, 2'b0};
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 32,
  parameter int CH_W         = 5,
  parameter int SETUP_TICKS  = 6,
  parameter int BASE_TICKS   = 25,
  parameter int MAX_AVG_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CH_W-1:0]   chanCode,
  output logic              irqEn,
  output logic [CFG_W-1:0]  cfgQ,
  output logic              avgEn,
  output logic              contEn,
  output logic [2:0]        avgShift,
  output seqStrobe_t        stb,
  output logic              busy,
  output logic              cvTick
);

  localparam int TICK_W = $clog2(BASE_TICKS + 26 + SETUP_TICKS);
  localparam int CNT_W  = MAX_AVG_LOG2;
  localparam logic [CH_W-1:0] DIS_CODE = {CH_W{1'b1}};

  seqState_t         state;
  logic [3:0]        divCnt;
  logic [3:0]        divLast;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] sampLast;
  logic [TICK_W-1:0] setupLast;
  logic [CNT_W-1:0]  sampCnt;
  logic [CNT_W-1:0]  nLast;
  logic [CNT_W:0]    nTmp;
  logic              chanWr;

  assign chanWr = regWe && (regAddr == ADDR_W'(A_CHAN));

  // Register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCode <= DIS_CODE;
      irqEn    <= 1'b0;
      cfgQ     <= '0;
      avgEn    <= 1'b0;
      contEn   <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_W'(A_CHAN): begin
          chanCode <= wrData[CH_W-1:0];
          irqEn    <= wrData[7];
        end
        ADDR_W'(A_CFG): cfgQ <= wrData[CFG_W-1:0];
        ADDR_W'(A_GEN): begin
          avgEn  <= wrData[5];
          contEn <= wrData[6];
        end
        default: ;
      endcase
    end
  end

  // Derived timing limits
  always_comb begin
    if (cfgQ[1:0] == 2'd1 && cfgQ[6:5] == 2'd3) divLast = 4'd15;
    else                                       divLast = (4'd1 << cfgQ[6:5]) - 4'd1;
    avgShift  = avgEn ? (3'd2 + {1'b0, cfgQ[15:14]}) : 3'd0;
    nTmp      = ({{CNT_W{1'b0}}, 1'b1} << avgShift) - 1'b1;
    nLast     = nTmp[CNT_W-1:0];
    sampLast  = TICK_W'(BASE_TICKS) + TICK_W'(lsAdder(cfgQ[4], cfgQ[9:8])) - TICK_W'(1);
    setupLast = TICK_W'(SETUP_TICKS - 1);
  end

  assign busy   = (state != ST_IDLE);
  assign cvTick = busy && (divCnt == divLast);

  always_comb begin
    stb.start    = chanWr && (wrData[CH_W-1:0] != DIS_CODE);
    stb.sampleEn = !chanWr && cvTick && (state == ST_SAMPLE) && (tickCnt == sampLast);
    stb.finish   = stb.sampleEn && (sampCnt == nLast);
  end

  // Phase sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      tickCnt <= '0;
      sampCnt <= '0;
    end else if (chanWr) begin
      state   <= (wrData[CH_W-1:0] == DIS_CODE) ? ST_IDLE : ST_SETUP;
      divCnt  <= '0;
      tickCnt <= '0;
      sampCnt <= '0;
    end else if (cvTick) begin
      divCnt <= '0;
      case (state)
        ST_SETUP: begin
          if (tickCnt == setupLast) begin
            state   <= ST_SAMPLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (tickCnt == sampLast) begin
            tickCnt <= '0;
            if (sampCnt == nLast) begin
              sampCnt <= '0;
              state   <= contEn ? ST_SETUP : ST_IDLE;
            end else begin
              sampCnt <= sampCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (busy) begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int ACC_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [RAW_W-1:0] rawSample,
  input  logic [1:0]       resSel,
  input  logic [2:0]       avgShift,
  input  logic             ovwEn,
  input  logic             rdClr,
  output logic [RAW_W-1:0] resultQ,
  output logic             doneFlag
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sumNext;
  logic [ACC_W-1:0] scaled;
  logic [RAW_W-1:0] resMask;
  logic [RAW_W-1:0] finalVal;

  always_comb begin
    sumNext = acc + ACC_W'(rawSample);
    scaled  = sumNext >> avgShift;
    case (resSel)
      2'd0:    resMask = {RAW_W{1'b1}} >> (RAW_W - 8);
      2'd1:    resMask = {RAW_W{1'b1}} >> (RAW_W - 10);
      default: resMask = {RAW_W{1'b1}};
    endcase
    finalVal = scaled[RAW_W-1:0] & resMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (stb.start) begin
      acc <= '0;
    end else if (stb.sampleEn) begin
      acc <= stb.finish ? '0 : sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (stb.finish && (!doneFlag || ovwEn)) resultQ <= finalVal;
      if (stb.finish)  doneFlag <= 1'b1;
      else if (rdClr)  doneFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 32,
  parameter int CH_W         = 5,
  parameter int RAW_W        = 12,
  parameter int ACC_W        = 17,
  parameter int SETUP_TICKS  = 6,
  parameter int BASE_TICKS   = 25,
  parameter int MAX_AVG_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [RAW_W-1:0]  rawSample,
  output logic [CH_W-1:0]   chanSel,
  output logic              convBusy,
  output logic              cvClkEn,
  output logic              irq
);

  seqStrobe_t       seqStb;
  logic             irqEn;
  logic [CFG_W-1:0] cfgQ;
  logic             avgEn;
  logic             contEn;
  logic [2:0]       avgShift;
  logic [RAW_W-1:0] resultQ;
  logic             doneFlag;
  logic             rdClr;
  logic             ovwEn;

  assign rdClr = regRe && (regAddr == ADDR_W'(A_RES));
  assign ovwEn = cfgQ[16];

  adc_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .SETUP_TICKS(SETUP_TICKS),
    .BASE_TICKS(BASE_TICKS), .MAX_AVG_LOG2(MAX_AVG_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .wrData(wrData),
    .chanCode(chanSel), .irqEn(irqEn), .cfgQ(cfgQ), .avgEn(avgEn), .contEn(contEn),
    .avgShift(avgShift), .stb(seqStb), .busy(convBusy), .cvTick(cvClkEn)
  );

  adc_seq_dpath #(.RAW_W(RAW_W), .ACC_W(ACC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(seqStb), .rawSample(rawSample),
    .resSel(cfgQ[3:2]), .avgShift(avgShift), .ovwEn(ovwEn), .rdClr(rdClr),
    .resultQ(resultQ), .doneFlag(doneFlag)
  );

  assign irq = doneFlag && irqEn;

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_W'(A_CHAN): begin
        rdData[CH_W-1:0] = chanSel;
        rdData[7]        = irqEn;
      end
      ADDR_W'(A_CFG):  rdData[CFG_W-1:0] = cfgQ;
      ADDR_W'(A_GEN):  begin
        rdData[5] = avgEn;
        rdData[6] = contEn;
      end
      ADDR_W'(A_STAT): rdData[0] = doneFlag;
      ADDR_W'(A_RES):  rdData[RAW_W-1:0] = resultQ;
      default: ;
    endcase
  end

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int RAW_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              convBusy,
  input logic              doneFlag,
  input logic [RAW_W-1:0]  resultQ,
  input logic              ovwEn,
  input logic              finish
);

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0) && wrData[4:0] != 5'h1F) |=> convBusy);

  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0) && wrData[4:0] == 5'h1F) |=> !convBusy);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == ADDR_W'(4) && !finish) |=> !doneFlag);

  a_r3_finish_flags: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> doneFlag);

  a_r10_keep_old: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !ovwEn) |=> $stable(resultQ));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW_W(RAW_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .wrData(wrData), .convBusy(convBusy), .doneFlag(doneFlag), .resultQ(resultQ),
  .ovwEn(ovwEn), .finish(seqStb.finish)
);

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [2:0]  regAddr = 3'd3;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [11:0] rawSample = '0;
  logic [4:0]  chanSel;
  logic        convBusy;
  logic        cvClkEn;
  logic        irq;

  int nChk = 0;
  int nBad = 0;
  int kNow = 0;
  int base = 0;

  always #2.5 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .rawSample(rawSample), .chanSel(chanSel),
    .convBusy(convBusy), .cvClkEn(cvClkEn), .irq(irq)
  );

  // Stimulus table: configuration word, general-control word, ramp base
  localparam logic [31:0] CFG_TAB [6] = '{32'h0000_0008, 32'h0000_0324, 32'h0000_4050,
                                          32'h0000_0179, 32'h0000_C278, 32'h0000_8318};
  localparam logic [31:0] GEN_TAB [6] = '{32'h0, 32'h20, 32'h20, 32'h0, 32'h20, 32'h20};
  localparam int          BASE_TAB[6] = '{100, 1000, 50, 4000, 7, 300};

  function automatic int lsOf(logic [31:0] c);
    int f = int'(c[9:8]);
    if (!c[4]) return 3 + 2 * f;
    return (f == 3) ? 25 : 13 + 4 * f;
  endfunction

  function automatic int divOf(logic [31:0] c);
    if (c[1:0] == 2'd1 && c[6:5] == 2'd3) return 16;
    return 1 << c[6:5];
  endfunction

  function automatic int shOf(logic [31:0] c, logic [31:0] g);
    return g[5] ? 2 + int'(c[15:14]) : 0;
  endfunction

  function automatic int expCycles(logic [31:0] c, logic [31:0] g);
    return divOf(c) * (6 + (1 << shOf(c, g)) * (25 + lsOf(c)));
  endfunction

  function automatic int expRes(logic [31:0] c, logic [31:0] g, int b);
    int sh = shOf(c, g);
    int s  = 25 + lsOf(c);
    int d  = divOf(c);
    int sum = 0;
    int mask = (c[3:2] == 2'd0) ? 255 : (c[3:2] == 2'd1) ? 1023 : 4095;
    for (int j = 1; j <= (1 << sh); j++) sum += (b + d * (6 + j * s)) % 4096;
    return (sum >> sh) & mask;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    kNow++;
    #1;
    rawSample = 12'((base + kNow + 1) % 4096);
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = 3'(a); wrData = d;
    cyc();
    regWe = 1'b0; regAddr = 3'd3;
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    regAddr = 3'(a);
    #1;
    v = rdData;
  endtask

  task automatic runTo(input int kEnd);
    while (kNow < kEnd) cyc();
  endtask

  task automatic readClear();
    regRe = 1'b1; regAddr = 3'd4;
    cyc();
    regRe = 1'b0; regAddr = 3'd3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tot, early;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R11: reset state
    peek(3, v); chk("R11 flag after reset", int'(v[0]), 0);
    peek(0, v); chk("R11 channel after reset", int'(v[7:0]), 8'h1F);
    peek(4, v); chk("R11 result after reset", int'(v), 0);
    chk("R11 busy after reset", int'(convBusy), 0);
    chk("R11 irq after reset", int'(irq), 0);

    // R1 / R2: start, then stop mid-conversion
    wrReg(1, 32'h8); wrReg(2, 32'h0);
    base = 0; kNow = -1;
    wrReg(0, 32'h83);
    runTo(20);
    chk("R1 busy after start", int'(convBusy), 1);
    chk("R1 chanSel", int'(chanSel), 3);
    peek(0, v); chk("R1 channel readback", int'(v[7:0]), 8'h83);
    wrReg(0, 32'h1F);
    runTo(100);
    chk("R2 busy after stop", int'(convBusy), 0);
    peek(3, v); chk("R2 no completion after stop", int'(v[0]), 0);
    chk("R2 irq after stop", int'(irq), 0);

    // Table walk: timing, adder, averaging, resolution, divider
    for (int i = 0; i < 6; i++) begin
      wrReg(1, CFG_TAB[i]); wrReg(2, GEN_TAB[i]);
      base = BASE_TAB[i]; kNow = -1;
      wrReg(0, 32'h80 | 32'(i + 2));
      tot = expCycles(CFG_TAB[i], GEN_TAB[i]);
      early = 0;
      while (kNow < tot - 1) begin
        peek(3, v);
        if (v[0]) early++;
        cyc();
      end
      peek(3, v);
      if (v[0]) early++;
      chk("R3 flag before last tick", early, 0);
      cyc();
      peek(3, v); chk("R3 R7 flag at deadline", int'(v[0]), 1);
      chk("R8 irq with enable", int'(irq), 1);
      chk("R3 idle after single", int'(convBusy), 0);
      chk("R1 chanSel in table", int'(chanSel), i + 2);
      peek(4, v);
      chk("R4 R5 R6 R7 result", int'(v), expRes(CFG_TAB[i], GEN_TAB[i], base));
      readClear();
      peek(3, v); chk("R8 flag cleared by read", int'(v[0]), 0);
      chk("R8 irq cleared", int'(irq), 0);
    end

    // R9 / R10: continuous mode with and without overwrite
    wrReg(1, 32'h8); wrReg(2, 32'h40);
    base = 500; kNow = -1;
    wrReg(0, 32'h05);
    runTo(68);
    peek(3, v); chk("R9 flag in continuous", int'(v[0]), 1);
    chk("R9 still busy", int'(convBusy), 1);
    chk("R8 irq masked when disabled", int'(irq), 0);
    peek(4, v); chk("R10 old result kept", int'(v), 534);
    wrReg(1, 32'h1_0008);
    runTo(102);
    peek(4, v); chk("R10 overwrite replaces", int'(v), 602);
    wrReg(2, 32'h0);
    runTo(136);
    peek(4, v); chk("R9 last conversion result", int'(v), 636);
    chk("R9 idle after continuous off", int'(convBusy), 0);
    runTo(200);
    chk("R9 stays idle", int'(convBusy), 0);
    peek(4, v); chk("R9 no further result", int'(v), 636);
    readClear();

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule